// File: doc/BRIEF.md
# ITU-R BT.656 Receive Stream Filter

This block sits behind a video input pin group and sees one BT.656 word per pixel clock. It looks for the embedded timing reference codes, decodes the field, vertical-blanking and horizontal flags they carry, and forwards only the words that belong to the capture window chosen by a two-bit mode input. The choices are the whole field, active picture only, or vertical-blanking lines only. Each forwarded word comes with a valid strobe. Region flags and a one-cycle field-change pulse travel alongside the output.

A timing reference code is only recognised once its fourth word has arrived. For that reason every word passes through a four-slot tag line, so a code that completes can still mark its three leading words before they reach the output. The `wide` input selects the word format. In 10-bit format the reference code sits in bits 9..2. In 8-bit format it sits in bits 7..0.

The sync detector is a state machine with four states. HUNT waits for an all-ones code. ONES has seen all-ones. ZERO1 has seen one zero code. ZERO2 has seen two zero codes, and the word in that state is the status word. Its transitions are as follows. An all-ones code moves any of HUNT, ONES and ZERO1 to ONES. A zero code moves ONES to ZERO1 and ZERO1 to ZERO2. Any other code returns HUNT, ONES and ZERO1 to HUNT. ZERO2 always returns to HUNT after taking the status word.

Top module: `vid656_filter`

## Requirements
- R1: After reset `out_valid`, `out_field`, `out_vblank` and `out_fchg` are 0 and `out_hblank` is 1. `out_valid` stays 0 until the fifth rising edge after reset release.
- R2: A word sampled at a rising edge appears on `out_word` after the fourth following rising edge, if it is forwarded. In 10-bit format (`wide`=1) all ten bits are forwarded unchanged.
- R3: A timing reference code is the code sequence 0xFF, 0x00, 0x00, then a status word. The code is `in_word[9:2]` when `wide`=1 and `in_word[7:0]` when `wide`=0. The status code carries F in bit 6, V in bit 5 and H in bit 4. H=1 marks end of active video and H=0 marks start of active video.
- R4: The F/V/H value of a status word is attached to all four words of its reference code and to every later word until the next status word. Before the first status word the flags are F=0, V=0, H=1. These flags of each word leave on `out_field`, `out_vblank` and `out_hblank` together with it.
- R5: With `mode` 0 or 3 (whole field), every word is forwarded.
- R6: With `mode` 1 (active picture), only words with V=0 and H=0 that are not part of a reference code are forwarded.
- R7: With `mode` 2 (blanking lines), every word with V=1 is forwarded, including the reference code words and the horizontal blanking data.
- R8: An all-ones code, or all-ones then zero, that does not complete a reference code is ordinary data with the current flags. An all-ones code after all-ones restarts the match, so 0xFF,0xFF,0x00,0x00,S is a valid code.
- R9: `out_fchg` is 1 for one cycle when the field flag of the word leaving the tag line differs from that of the previous word. The field flag counts as 0 before the first word.
- R10: In 8-bit format (`wide`=0) bits 9..8 of a forwarded word are 0, whatever the input drove there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, one word per rising edge |
| rst_n | input | 1 | Active-low reset |
| in_word | input | 10 | Incoming stream word |
| wide | input | 1 | 1: 10-bit words, 0: 8-bit words in bits 7..0 |
| mode | input | 2 | 0/3 whole field, 1 active picture, 2 blanking lines |
| out_word | output | 10 | Forwarded word |
| out_valid | output | 1 | `out_word` holds a forwarded word |
| out_field | output | 1 | F flag of the word leaving the tag line |
| out_vblank | output | 1 | V flag of the word leaving the tag line |
| out_hblank | output | 1 | H flag of the word leaving the tag line |
| out_fchg | output | 1 | Field flag changed with this word |

## Verification
The assertions take the stream to be gap-free, one word on every edge. They also take `mode` and `wide` to be held steady across a word's five-edge flight, because the whole-field latency property compares the output against the input five edges back. The bench holds both inputs constant for a complete synthesised frame and changes them only under reset. Every frame is built line by line from generated reference codes, random picture words and deliberate broken or doubled code starts.

// File: rtl/vid656_pkg.sv
`timescale 1ns/1ps
package vid656_pkg;
    localparam int CODE_W  = 8;
    localparam int PRE_LEN = 4;
    localparam int F_BIT   = 6;
    localparam int V_BIT   = 5;
    localparam int H_BIT   = 4;

    typedef enum logic [1:0] {
        CAP_ALL     = 2'd0,
        CAP_ACTIVE  = 2'd1,
        CAP_VBI     = 2'd2,
        CAP_ALL_ALT = 2'd3
    } cap_mode_e;

    typedef enum logic [1:0] {
        SY_HUNT  = 2'd0,
        SY_ONES  = 2'd1,
        SY_ZERO1 = 2'd2,
        SY_ZERO2 = 2'd3
    } sync_state_e;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } region_t;

    localparam region_t REGION_RST = '{f: 1'b0, v: 1'b0, h: 1'b1};
endpackage

// File: rtl/vid656_sync.sv
`timescale 1ns/1ps
module vid656_sync
    import vid656_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] word,
    input  logic              wide,
    output logic              hit,
    output region_t           hit_region,
    output region_t           region_q
);
    logic [CODE_W-1:0] code;
    logic              is_ones;
    logic              is_zero;
    sync_state_e       st;
    sync_state_e       st_nx;

    always_comb begin
        code    = wide ? word[DATA_W-1 -: CODE_W] : word[CODE_W-1:0];
        is_ones = &code;
        is_zero = (code == '0);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SY_HUNT;
        else        st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = SY_HUNT;
        unique case (st)
            SY_HUNT:  st_nx = is_ones ? SY_ONES : SY_HUNT;
            SY_ONES:  st_nx = is_ones ? SY_ONES : (is_zero ? SY_ZERO1 : SY_HUNT);
            SY_ZERO1: st_nx = is_ones ? SY_ONES : (is_zero ? SY_ZERO2 : SY_HUNT);
            SY_ZERO2: st_nx = SY_HUNT;
        endcase
    end

    // outputs: status decode and latched region
    always_comb begin
        hit        = (st == SY_ZERO2);
        hit_region = '{f: code[F_BIT], v: code[V_BIT], h: code[H_BIT]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   region_q <= REGION_RST;
        else if (hit) region_q <= hit_region;
    end
endmodule

// File: rtl/vid656_tagline.sv
`timescale 1ns/1ps
module vid656_tagline
    import vid656_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int DEPTH  = PRE_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] word,
    input  logic              hit,
    input  region_t           hit_region,
    input  region_t           region_q,
    output logic              tail_vld,
    output logic              tail_pre,
    output region_t           tail_rg,
    output logic [DATA_W-1:0] tail_word
);
    logic [DEPTH-1:0]  vld;
    logic [DEPTH-1:0]  pre;
    region_t           rg [DEPTH];
    logic [DATA_W-1:0] w  [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
            pre <= '0;
            for (int k = 0; k < DEPTH; k++) begin
                rg[k] <= REGION_RST;
                w[k]  <= '0;
            end
        end else begin
            vld[0] <= 1'b1;
            pre[0] <= hit;
            rg[0]  <= hit ? hit_region : region_q;
            w[0]   <= word;
            for (int k = 1; k < DEPTH; k++) begin
                vld[k] <= vld[k-1];
                w[k]   <= w[k-1];
                // the three words ahead of a status word are its code
                if (hit && k < PRE_LEN) begin
                    pre[k] <= 1'b1;
                    rg[k]  <= hit_region;
                end else begin
                    pre[k] <= pre[k-1];
                    rg[k]  <= rg[k-1];
                end
            end
        end
    end

    always_comb begin
        tail_vld  = vld[DEPTH-1];
        tail_pre  = pre[DEPTH-1];
        tail_rg   = rg[DEPTH-1];
        tail_word = w[DEPTH-1];
    end
endmodule

// File: rtl/vid656_gate.sv
`timescale 1ns/1ps
module vid656_gate
    import vid656_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cap_mode_e         mode,
    input  logic              tail_vld,
    input  logic              tail_pre,
    input  region_t           tail_rg,
    input  logic [DATA_W-1:0] tail_word,
    output logic [DATA_W-1:0] out_word,
    output logic              out_valid,
    output logic              out_field,
    output logic              out_vblank,
    output logic              out_hblank,
    output logic              out_fchg
);
    logic keep;

    always_comb begin
        keep = 1'b0;
        unique case (mode)
            CAP_ALL, CAP_ALL_ALT: keep = 1'b1;
            CAP_ACTIVE:           keep = !tail_pre && !tail_rg.v && !tail_rg.h;
            CAP_VBI:              keep = tail_rg.v;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_word   <= '0;
            out_valid  <= 1'b0;
            out_field  <= REGION_RST.f;
            out_vblank <= REGION_RST.v;
            out_hblank <= REGION_RST.h;
            out_fchg   <= 1'b0;
        end else begin
            out_valid <= tail_vld && keep;
            out_fchg  <= tail_vld && (tail_rg.f != out_field);
            if (tail_vld) begin
                out_word   <= tail_word;
                out_field  <= tail_rg.f;
                out_vblank <= tail_rg.v;
                out_hblank <= tail_rg.h;
            end
        end
    end
endmodule

// File: rtl/vid656_filter.sv
`timescale 1ns/1ps
module vid656_filter
    import vid656_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_word,
    input  logic              wide,
    input  logic [1:0]        mode,
    output logic [DATA_W-1:0] out_word,
    output logic              out_valid,
    output logic              out_field,
    output logic              out_vblank,
    output logic              out_hblank,
    output logic              out_fchg
);
    localparam int LINE_DEPTH = PRE_LEN;

    logic              status_hit;
    region_t           status_region;
    region_t           region_q;
    logic [DATA_W-1:0] word_fmt;
    logic              tail_vld;
    logic              tail_pre;
    region_t           tail_rg;
    logic [DATA_W-1:0] tail_word;
    cap_mode_e         mode_e;

    always_comb begin
        word_fmt = wide ? in_word : DATA_W'(in_word[CODE_W-1:0]);
        mode_e   = cap_mode_e'(mode);
    end

    vid656_sync #(.DATA_W(DATA_W)) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .word       (in_word),
        .wide       (wide),
        .hit        (status_hit),
        .hit_region (status_region),
        .region_q   (region_q)
    );

    vid656_tagline #(.DATA_W(DATA_W), .DEPTH(LINE_DEPTH)) i_tag (
        .clk        (clk),
        .rst_n      (rst_n),
        .word       (word_fmt),
        .hit        (status_hit),
        .hit_region (status_region),
        .region_q   (region_q),
        .tail_vld   (tail_vld),
        .tail_pre   (tail_pre),
        .tail_rg    (tail_rg),
        .tail_word  (tail_word)
    );

    vid656_gate #(.DATA_W(DATA_W)) i_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_e),
        .tail_vld   (tail_vld),
        .tail_pre   (tail_pre),
        .tail_rg    (tail_rg),
        .tail_word  (tail_word),
        .out_word   (out_word),
        .out_valid  (out_valid),
        .out_field  (out_field),
        .out_vblank (out_vblank),
        .out_hblank (out_hblank),
        .out_fchg   (out_fchg)
    );
endmodule

// File: rtl/vid656_filter_chk.sv
`timescale 1ns/1ps
module vid656_filter_chk
    import vid656_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] in_word,
    input logic              wide,
    input logic [1:0]        mode,
    input logic [DATA_W-1:0] out_word,
    input logic              out_valid,
    input logic              out_field,
    input logic              out_vblank,
    input logic              out_hblank,
    input logic              out_fchg,
    input logic              status_hit,
    input region_t           region_q
);
    logic [3:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 since_rst <= '0;
        else if (since_rst != 4'hF) since_rst <= since_rst + 4'd1;
    end

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < 4'd5) |-> !out_valid);

    p_whole_field_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4'd6 && $past(wide, 5) && ($past(mode) == 2'd0 || $past(mode) == 2'd3))
        |-> (out_valid && out_word == $past(in_word, 5)));

    p_flags_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(status_hit) |-> $stable(region_q));

    p_active_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && since_rst >= 4'd2 && $past(mode) == 2'd1) |-> (!out_vblank && !out_hblank));

    p_blank_lines_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && since_rst >= 4'd2 && $past(mode) == 2'd2) |-> out_vblank);

    p_field_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_fchg && since_rst >= 4'd2) |-> (out_field != $past(out_field)));

    p_narrow_pad_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4'd6 && !$past(wide, 5) && ($past(mode) == 2'd0 || $past(mode) == 2'd3))
        |-> (out_word[DATA_W-1:CODE_W] == '0));
endmodule

bind vid656_filter vid656_filter_chk #(.DATA_W(DATA_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_word    (in_word),
    .wide       (wide),
    .mode       (mode),
    .out_word   (out_word),
    .out_valid  (out_valid),
    .out_field  (out_field),
    .out_vblank (out_vblank),
    .out_hblank (out_hblank),
    .out_fchg   (out_fchg),
    .status_hit (status_hit),
    .region_q   (region_q)
);

// File: tb/test_vid656_filter.sv
`timescale 1ns/1ps
module test_vid656_filter;
    localparam int MAXW  = 2048;
    localparam int LINES = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] in_word = '0;
    logic       wide = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [9:0] out_word;
    logic       out_valid, out_field, out_vblank, out_hblank, out_fchg;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;

    int         n;
    logic [9:0] stim  [MAXW];
    bit         part  [MAXW];
    bit         pre_e [MAXW];
    bit         f_e   [MAXW];
    bit         v_e   [MAXW];
    bit         h_e   [MAXW];

    always #2.5 clk = ~clk;

    vid656_filter i_vid656_filter (
        .clk(clk), .rst_n(rst_n), .in_word(in_word), .wide(wide), .mode(mode),
        .out_word(out_word), .out_valid(out_valid), .out_field(out_field),
        .out_vblank(out_vblank), .out_hblank(out_hblank), .out_fchg(out_fchg)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] status_code(input bit f, input bit v, input bit h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    // place an 8-bit code in the chosen format with random spare bits
    task automatic emit(input logic [7:0] code, input bit is_part, input bit wd);
        logic [1:0] junk;
        junk = 2'($urandom);
        stim[n] = wd ? {code, junk} : {junk, code};
        part[n] = is_part;
        n++;
    endtask

    task automatic emit_ref(input bit f, input bit v, input bit h, input bit wd);
        if ($urandom % 4 == 0) emit(8'hFF, 1'b1, wd);  // doubled start
        emit(8'hFF, 1'b0, wd);
        emit(8'h00, 1'b0, wd);
        emit(8'h00, 1'b0, wd);
        emit(status_code(f, v, h), 1'b0, wd);
    endtask

    task automatic emit_data(input int cnt, input bit wd);
        for (int i = 0; i < cnt; i++) emit(8'(8'h10 + ($urandom % 8'hE0)), 1'b0, wd);
    endtask

    task automatic build(input bit wd);
        n = 0;
        for (int ln = 0; ln < LINES; ln++) begin
            bit f, v;
            f = (ln >= LINES / 2);
            v = ((ln % (LINES / 2)) < 4);
            emit_ref(f, v, 1'b1, wd);
            emit_data(6 + $urandom % 4, wd);
            if ($urandom % 3 == 0) begin           // broken code start
                emit(8'hFF, 1'b1, wd);
                emit(8'h00, 1'b1, wd);
            end
            emit_data(2, wd);
            emit_ref(f, v, 1'b0, wd);
            emit_data(12 + $urandom % 8, wd);
        end
    endtask

    // expected tags from the code rules of R3, R4, R8
    task automatic model(input bit wd);
        int  s;
        bit  cf, cv, ch;
        s = 0; cf = 0; cv = 0; ch = 1;
        for (int i = 0; i < n; i++) begin
            logic [7:0] c;
            c = wd ? stim[i][9:2] : stim[i][7:0];
            pre_e[i] = 0; f_e[i] = cf; v_e[i] = cv; h_e[i] = ch;
            if (s == 3) begin
                cf = c[6]; cv = c[5]; ch = c[4];
                for (int j = i - 3; j <= i; j++) begin
                    pre_e[j] = 1; f_e[j] = cf; v_e[j] = cv; h_e[j] = ch;
                end
                s = 0;
            end else if (c == 8'hFF) s = 1;
            else if (c == 8'h00 && (s == 1 || s == 2)) s = s + 1;
            else s = 0;
        end
    endtask

    function automatic bit exp_pass(input int md, input int k);
        case (md)
            1:       return !pre_e[k] && !v_e[k] && !h_e[k];
            2:       return v_e[k];
            default: return 1'b1;
        endcase
    endfunction

    task automatic run(input int md, input bit wd);
        build(wd);
        model(wd);
        rst_n = 1'b0;
        mode = 2'(md);
        wide = wd;
        repeat (4) @(negedge clk);
        for (int c = 0; c < n + 5; c++) begin
            int k;
            if (c != 0) @(negedge clk);
            k = c - 5;
            if (c == 0) begin
                chk(out_field == 0,  "R1 field", out_field, 0);
                chk(out_vblank == 0, "R1 vblank", out_vblank, 0);
                chk(out_hblank == 1, "R1 hblank", out_hblank, 1);
                chk(out_fchg == 0,   "R1 fchg", out_fchg, 0);
            end
            if (k < 0) begin
                chk(out_valid == 0, "R1 valid", out_valid, 0);
            end else begin
                bit    ep, prevf;
                string tag;
                logic [9:0] ew;
                ep = exp_pass(md, k);
                tag = part[k] ? "R8 valid" : pre_e[k] ? "R3 valid" :
                      (md == 1) ? "R6 valid" : (md == 2) ? "R7 valid" : "R5 valid";
                chk(out_valid == ep, tag, out_valid, ep);
                if (ep) begin
                    ew = wd ? stim[k] : {2'b00, stim[k][7:0]};
                    chk(out_word == ew, wd ? "R2 word" : "R10 word", out_word, ew);
                end
                chk({out_field, out_vblank, out_hblank} == {f_e[k], v_e[k], h_e[k]},
                    "R4 flags", {out_field, out_vblank, out_hblank}, {f_e[k], v_e[k], h_e[k]});
                prevf = (k == 0) ? 1'b0 : f_e[k-1];
                chk(out_fchg == (f_e[k] != prevf), "R9 fchg", out_fchg, f_e[k] != prevf);
            end
            in_word = (c < n) ? stim[c] : 10'h040;
            rst_n = 1'b1;
        end
    endtask

    initial begin
        void'($urandom(32'h0656_5EED));
        run(1, 1'b0);
        run(2, 1'b1);
        run(0, 1'b0);
        run(3, 1'b1);
        run(1, 1'b1);
        run(2, 1'b0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule